// File: doc/BRIEF.md
# External Data Memory Address Router

This block sits between a processor's data-memory request port and two kinds of storage in a 16-bit (64 KB) external data address space. One is a 4 KB RAM on the same die. The other is memory reached through a set of bus pins. A two-bit mapping field decides where each request goes. Every access can go to the on-die RAM, every access can go to the pins, or the space can be split at the 4 KB line.

The pin-side bus has two timings, and a single configuration bit picks one of them at run time. In the multiplexed timing, the low address byte first appears on the shared data pins while an address-latch strobe is high. A read or write strobe follows. In the non-multiplexed timing, the whole address sits on dedicated pins and the strobe starts at once. In both timings the strobe stays low for a programmable number of extra wait cycles.

The requester holds its request until the block reports completion. An on-die access completes in the cycle it is presented. An off-die access completes the cycle after its strobe is released.

Top module: `xmem_router`

## Requirements
- R1: `cfg_map` is decoded as 2'b00 = all addresses go to the on-die RAM, 2'b01 = split, and 2'b10 or 2'b11 = all addresses go to the pins. In the all-on-die mode, any 16-bit address reaches RAM word `req_addr[11:0]`, so the upper bits alias.
- R2: In split mode, addresses 0x0000 to 0x0FFF go to the on-die RAM and addresses 0x1000 to 0xFFFF go to the pins.
- R3: An on-die access raises `ram_en` combinationally in the cycle it is presented, with `ram_addr = req_addr[11:0]`, `ram_we = req_write` and `ram_wdata = req_wdata`. `req_done` is high in that same cycle, with `req_rdata = ram_rdata`.
- R4: With `cfg_muxed` = 1, an off-die access begins with exactly one cycle in which `ext_ale` = 1, `ext_ad_oe` = 1, `ext_ad_out = addr[7:0]` and `ext_addr_hi = addr[15:8]`. The strobe phase starts in the next cycle.
- R5: With `cfg_muxed` = 0, `ext_ale` never rises. During the strobe phase `ext_addr_hi = addr[15:8]` and `ext_addr_lo = addr[7:0]`.
- R6: The strobe phase lasts `cfg_wait`+1 consecutive cycles. `ext_rd_n` is low for reads and `ext_wr_n` is low for writes, never both. During a write, `ext_ad_out` carries the write data with `ext_ad_oe` = 1; during a read, `ext_ad_oe` = 0.
- R7: A read samples `ext_ad_in` at the clock edge that ends the last strobe cycle. `req_done` rises in the very next cycle, with that byte on `req_rdata`.
- R8: For an off-die access, `req_done` is a single-cycle pulse.
- R9: The bus timing (`cfg_muxed`, `cfg_wait`) is captured when an off-die access is accepted. Changes to the configuration during the access do not alter its ALE count or its strobe length.
- R10: During reset, `ext_rd_n` = `ext_wr_n` = 1, `ext_ale` = 0, `ext_ad_oe` = 0 and `req_done` = 0.
- R11: An on-die access leaves the pins idle (both strobes high, `ext_ale` low). An off-die access never raises `ram_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_map | input | 2 | Mapping mode |
| cfg_muxed | input | 1 | 1 = multiplexed pin timing |
| cfg_wait | input | 3 | Extra strobe wait cycles |
| req_valid | input | 1 | Request present, held until done |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | Byte address |
| req_wdata | input | 8 | Write data |
| req_done | output | 1 | Access completes this cycle |
| req_rdata | output | 8 | Read data, valid with req_done |
| ram_en | output | 1 | On-die RAM select |
| ram_we | output | 1 | On-die RAM write enable |
| ram_addr | output | 12 | On-die RAM word address |
| ram_wdata | output | 8 | On-die RAM write data |
| ram_rdata | input | 8 | On-die RAM read data (asynchronous read) |
| ext_addr_hi | output | 8 | Upper address byte pins |
| ext_addr_lo | output | 8 | Lower address byte pins (non-multiplexed timing) |
| ext_ad_out | output | 8 | Shared address/data pins, driven value |
| ext_ad_oe | output | 1 | Drive enable for the shared pins |
| ext_ad_in | input | 8 | Shared pins, sampled value |
| ext_ale | output | 1 | Address latch strobe |
| ext_rd_n | output | 1 | Read strobe, active low |
| ext_wr_n | output | 1 | Write strobe, active low |

## Verification
The bench targets the 4 KB boundary in split mode (0x0FFF and 0x1000). A decoder with an off-by-one or an inverted compare would send one of these to the wrong side, and then either no strobe would appear or a RAM write would land where it should not. Aliasing is tested by writing on-die through a low address and reading back through a high one in all-on-die mode; a router that passed upper bits through would return the wrong byte. Strobe length is counted for wait values from zero to seven. The bench also flips `cfg_muxed` and `cfg_wait` in the middle of an access, so a design that reads the live configuration instead of a captured copy shows a wrong ALE count or strobe length. Off-die read data comes from an address-derived function, so a wrong address on the pins or a mistimed sample shows up in `req_rdata`.

// File: rtl/xmem_pkg.sv
// Shared types for the external data memory router.
// Assumes nothing beyond the encodings listed here.
package xmem_pkg;
    // Mapping mode encoding; both 2'b10 and 2'b11 route everything off-die.
    typedef enum logic [1:0] {
        MAP_ONDIE     = 2'b00,
        MAP_SPLIT     = 2'b01,
        MAP_OFFDIE    = 2'b10,
        MAP_OFFDIE_B  = 2'b11
    } map_mode_e;

    // Off-die bus sequencer states.
    typedef enum logic [1:0] {
        BS_IDLE   = 2'b00,
        BS_ALE    = 2'b01,
        BS_STROBE = 2'b10,
        BS_DONE   = 2'b11
    } bus_state_e;
endpackage

// File: rtl/xmem_decode.sv
// Target decoder: tells whether an address maps to the on-die RAM under
// the given mapping mode. Purely combinational. Assumes the on-die RAM
// occupies the lowest 2**ONDIE_AW bytes of the space.
module xmem_decode
    import xmem_pkg::*;
#(
    parameter int ADDR_W   = 16,
    parameter int ONDIE_AW = 12
) (
    input  logic [1:0]        map_mode,
    input  logic [ADDR_W-1:0] addr,
    output logic              to_ondie
);
    localparam int HI_W = ADDR_W - ONDIE_AW;

    logic [HI_W-1:0] upper;
    assign upper = addr[ADDR_W-1:ONDIE_AW];

    // Select the target from mode and upper address bits.
    always_comb begin
        case (map_mode_e'(map_mode))
            MAP_ONDIE: to_ondie = 1'b1;
            MAP_SPLIT: to_ondie = (upper == '0);
            default:   to_ondie = 1'b0;
        endcase
    end
endmodule

// File: rtl/xmem_bus_seq.sv
// Off-die bus sequencer. On start it captures the request and the bus
// timing, then runs an optional address-latch cycle (multiplexed timing),
// a strobe phase of wait+1 cycles and a one-cycle done phase.
// Assumes start is only raised while idle and the request is held.
module xmem_bus_seq
    import xmem_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8,
    parameter int WAIT_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              write,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              muxed,
    input  logic [WAIT_W-1:0] wait_cfg,
    output logic              idle,
    output logic              done,
    output logic [DATA_W-1:0] rdata,
    output logic [ADDR_W-DATA_W-1:0] ext_addr_hi,
    output logic [DATA_W-1:0] ext_addr_lo,
    output logic [DATA_W-1:0] ext_ad_out,
    output logic              ext_ad_oe,
    input  logic [DATA_W-1:0] ext_ad_in,
    output logic              ext_ale,
    output logic              ext_rd_n,
    output logic              ext_wr_n
);
    localparam int HI_W = ADDR_W - DATA_W;

    bus_state_e        state;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;
    logic [DATA_W-1:0] rdata_q;
    logic              write_q;
    logic              muxed_q;
    logic [WAIT_W-1:0] wait_q;
    logic [WAIT_W-1:0] cnt;

    // Sequencer state, captured request and read-data sampling.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= BS_IDLE;
            addr_q  <= '0;
            wdata_q <= '0;
            rdata_q <= '0;
            write_q <= 1'b0;
            muxed_q <= 1'b0;
            wait_q  <= '0;
            cnt     <= '0;
        end else begin
            case (state)
                BS_IDLE: if (start) begin
                    addr_q  <= addr;
                    wdata_q <= wdata;
                    write_q <= write;
                    muxed_q <= muxed;
                    wait_q  <= wait_cfg;
                    cnt     <= wait_cfg;
                    state   <= muxed ? BS_ALE : BS_STROBE;
                end
                BS_ALE: state <= BS_STROBE;
                BS_STROBE: begin
                    if (cnt == '0) begin
                        state <= BS_DONE;
                        if (!write_q) rdata_q <= ext_ad_in;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                default: state <= BS_IDLE;
            endcase
        end
    end

    logic in_ale, in_strobe;
    assign in_ale    = (state == BS_ALE);
    assign in_strobe = (state == BS_STROBE);

    // Pin values for the current phase.
    always_comb begin
        ext_ale     = in_ale;
        ext_addr_hi = (in_ale || in_strobe) ? addr_q[ADDR_W-1:DATA_W] : '0;
        ext_addr_lo = (in_strobe && !muxed_q) ? addr_q[DATA_W-1:0] : '0;
        ext_ad_oe   = in_ale || (in_strobe && write_q);
        if (in_ale)                    ext_ad_out = addr_q[DATA_W-1:0];
        else if (in_strobe && write_q) ext_ad_out = wdata_q;
        else                           ext_ad_out = '0;
        ext_rd_n    = !(in_strobe && !write_q);
        ext_wr_n    = !(in_strobe && write_q);
    end

    assign idle  = (state == BS_IDLE);
    assign done  = (state == BS_DONE);
    assign rdata = rdata_q;

    // Checker state: length of the current strobe run.
    logic [WAIT_W:0] strb_len;
    always_ff @(posedge clk) begin
        if (!rst_n)                     strb_len <= '0;
        else if (!ext_rd_n || !ext_wr_n) strb_len <= strb_len + 1'b1;
        else                            strb_len <= '0;
    end

    // R4: the address-latch cycle is followed directly by a strobe.
    p_ale_then_strobe_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ext_ale |=> (!ext_rd_n || !ext_wr_n));

    // R5: a non-multiplexed start never produces an address-latch cycle.
    p_no_ale_direct_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (idle && start && !muxed) |=> !ext_ale);

    // R6: every strobe run lasts the captured wait value plus one.
    p_strobe_len_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ext_rd_n && ext_wr_n) |-> (strb_len == ({1'b0, wait_q} + 1'b1)));

    // R7: completion follows the strobe release.
    p_done_after_strobe_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ext_rd_n && ext_wr_n) |-> done);

    // R8: completion is a single-cycle pulse.
    p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    logic unused_hi;
    assign unused_hi = ^HI_W;
endmodule

// File: rtl/xmem_router.sv
// External data memory router top. Decodes each held request against the
// mapping mode; on-die requests are served combinationally through the
// RAM port, off-die requests are handed to the bus sequencer.
// Assumes the RAM has asynchronous read and writes on the clock edge,
// and that the requester holds its request until req_done.
module xmem_router
    import xmem_pkg::*;
#(
    parameter int ADDR_W   = 16,
    parameter int DATA_W   = 8,
    parameter int ONDIE_AW = 12,
    parameter int WAIT_W   = 3
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [1:0]               cfg_map,
    input  logic                     cfg_muxed,
    input  logic [WAIT_W-1:0]        cfg_wait,
    input  logic                     req_valid,
    input  logic                     req_write,
    input  logic [ADDR_W-1:0]        req_addr,
    input  logic [DATA_W-1:0]        req_wdata,
    output logic                     req_done,
    output logic [DATA_W-1:0]        req_rdata,
    output logic                     ram_en,
    output logic                     ram_we,
    output logic [ONDIE_AW-1:0]      ram_addr,
    output logic [DATA_W-1:0]        ram_wdata,
    input  logic [DATA_W-1:0]        ram_rdata,
    output logic [ADDR_W-DATA_W-1:0] ext_addr_hi,
    output logic [DATA_W-1:0]        ext_addr_lo,
    output logic [DATA_W-1:0]        ext_ad_out,
    output logic                     ext_ad_oe,
    input  logic [DATA_W-1:0]        ext_ad_in,
    output logic                     ext_ale,
    output logic                     ext_rd_n,
    output logic                     ext_wr_n
);
    logic              to_ondie;
    logic              seq_idle;
    logic              seq_done;
    logic              seq_start;
    logic [DATA_W-1:0] seq_rdata;

    xmem_decode #(.ADDR_W(ADDR_W), .ONDIE_AW(ONDIE_AW)) u_decode (
        .map_mode (cfg_map),
        .addr     (req_addr),
        .to_ondie (to_ondie)
    );

    // Route the held request to one side only.
    always_comb begin
        ram_en    = req_valid && to_ondie && seq_idle;
        seq_start = req_valid && !to_ondie && seq_idle;
        ram_we    = ram_en && req_write;
        ram_addr  = req_addr[ONDIE_AW-1:0];
        ram_wdata = req_wdata;
        req_done  = ram_en || seq_done;
        req_rdata = ram_en ? ram_rdata : seq_rdata;
    end

    xmem_bus_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .WAIT_W(WAIT_W)) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (seq_start),
        .write       (req_write),
        .addr        (req_addr),
        .wdata       (req_wdata),
        .muxed       (cfg_muxed),
        .wait_cfg    (cfg_wait),
        .idle        (seq_idle),
        .done        (seq_done),
        .rdata       (seq_rdata),
        .ext_addr_hi (ext_addr_hi),
        .ext_addr_lo (ext_addr_lo),
        .ext_ad_out  (ext_ad_out),
        .ext_ad_oe   (ext_ad_oe),
        .ext_ad_in   (ext_ad_in),
        .ext_ale     (ext_ale),
        .ext_rd_n    (ext_rd_n),
        .ext_wr_n    (ext_wr_n)
    );

    // R11: an on-die access leaves the pins idle.
    p_ondie_pins_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        ram_en |-> (ext_rd_n && ext_wr_n && !ext_ale));

    // R11: once an off-die access is accepted, the RAM stays deselected next cycle.
    p_offdie_no_ram_r11: assert property (@(posedge clk) disable iff (!rst_n)
        seq_start |=> !ram_en);

    // R2: in split mode, a valid address at or above 4 KB never selects the RAM.
    p_split_upper_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_map == MAP_SPLIT && req_valid && req_addr[ADDR_W-1:ONDIE_AW] != '0) |-> !ram_en);
endmodule

// File: tb/xmem_router_bench.sv
`timescale 1ns/1ps
module xmem_router_bench;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [1:0]  cfg_map;
    logic        cfg_muxed;
    logic [2:0]  cfg_wait;
    logic        req_valid, req_write;
    logic [15:0] req_addr;
    logic [7:0]  req_wdata;
    logic        req_done;
    logic [7:0]  req_rdata;
    logic        ram_en, ram_we;
    logic [11:0] ram_addr;
    logic [7:0]  ram_wdata, ram_rdata;
    logic [7:0]  ext_addr_hi, ext_addr_lo, ext_ad_out, ext_ad_in;
    logic        ext_ad_oe, ext_ale, ext_rd_n, ext_wr_n;

    int n_checks = 0;
    int n_fail   = 0;

    always #10 clk = ~clk;

    xmem_router u_xmem_router (
        .clk(clk), .rst_n(rst_n), .cfg_map(cfg_map), .cfg_muxed(cfg_muxed),
        .cfg_wait(cfg_wait), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_done(req_done),
        .req_rdata(req_rdata), .ram_en(ram_en), .ram_we(ram_we),
        .ram_addr(ram_addr), .ram_wdata(ram_wdata), .ram_rdata(ram_rdata),
        .ext_addr_hi(ext_addr_hi), .ext_addr_lo(ext_addr_lo),
        .ext_ad_out(ext_ad_out), .ext_ad_oe(ext_ad_oe), .ext_ad_in(ext_ad_in),
        .ext_ale(ext_ale), .ext_rd_n(ext_rd_n), .ext_wr_n(ext_wr_n)
    );

    // Reference functions
    function automatic logic [7:0] ext_fn(input logic [15:0] a);
        return {a[3:0], a[15:12]} ^ a[11:4] ^ 8'h5A;
    endfunction
    function automatic logic [7:0] ram_init(input logic [11:0] a);
        return a[7:0] ^ {a[11:8], a[11:8]} ^ 8'hC3;
    endfunction
    function automatic bit exp_ondie(input logic [1:0] m, input logic [15:0] a);
        if (m == 2'b00) return 1'b1;
        if (m == 2'b01) return a < 16'h1000;
        return 1'b0;
    endfunction

    // On-die RAM model and an independent shadow
    logic [7:0] ram_mem [4096];
    logic [7:0] shadow  [4096];
    assign ram_rdata = ram_mem[ram_addr];
    always @(posedge clk) if (ram_en && ram_we) ram_mem[ram_addr] <= ram_wdata;

    // Off-die memory model
    bit         bmux;
    logic [7:0] lat_lo;
    int         ext_wr_cnt = 0;
    logic [15:0] ext_wr_addr;
    logic [7:0]  ext_wr_data;
    logic [15:0] cur_ext_addr;
    assign cur_ext_addr = bmux ? {ext_addr_hi, lat_lo} : {ext_addr_hi, ext_addr_lo};
    assign ext_ad_in = ext_fn(cur_ext_addr);
    always @(posedge clk) begin
        if (ext_ale) lat_lo <= ext_ad_out;
        if (!ext_wr_n) begin
            ext_wr_cnt  <= ext_wr_cnt + 1;
            ext_wr_addr <= cur_ext_addr;
            ext_wr_data <= ext_ad_out;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", req, act, exp, $time);
        end
    endtask

    // One access from request to release; starts and ends just after a negedge.
    task automatic run(input bit wr, input logic [15:0] a, input logic [7:0] d,
                       input logic [1:0] m, input bit mx, input logic [2:0] w,
                       input bit flip);
        int ale_cnt = 0, s_cnt = 0, cyc = 0;
        bit last_strobe = 0, seen_done = 0;
        int wr_before;
        cfg_map = m; cfg_muxed = mx; cfg_wait = w;
        req_write = wr; req_addr = a; req_wdata = d; req_valid = 1'b1;
        bmux = mx;
        wr_before = ext_wr_cnt;
        #1;
        if (exp_ondie(m, a)) begin
            check(ram_en == 1'b1, "R1/R2 on-die select", ram_en, 1);
            check(ram_addr == a[11:0], "R1 alias address", ram_addr, a[11:0]);
            check(req_done == 1'b1, "R3 same-cycle done", req_done, 1);
            check(ram_we == wr, "R3 write enable", ram_we, wr);
            if (!wr) check(req_rdata == shadow[a[11:0]], "R3 read data", req_rdata, shadow[a[11:0]]);
            else check(ram_wdata == d, "R3 write data", ram_wdata, d);
            check(ext_rd_n && ext_wr_n && !ext_ale, "R11 pins idle on on-die", {ext_rd_n, ext_wr_n, ext_ale}, 3'b110);
            if (wr) shadow[a[11:0]] = d;
            @(posedge clk);
            @(negedge clk);
            req_valid = 1'b0;
        end else begin
            check(ram_en == 1'b0, "R2/R11 no RAM select off-die", ram_en, 0);
            @(posedge clk);
            while (!seen_done) begin
                @(negedge clk);
                #1;
                cyc++;
                if (cyc > 40) begin
                    check(1'b0, "R7 access never completed", cyc, w + 3);
                    break;
                end
                check(ram_en == 1'b0, "R11 RAM idle during off-die", ram_en, 0);
                if (ext_ale) begin
                    ale_cnt++;
                    check(ext_ad_out == a[7:0] && ext_ad_oe, "R4 low address on shared pins", ext_ad_out, a[7:0]);
                    check(ext_addr_hi == a[15:8], "R4 high address", ext_addr_hi, a[15:8]);
                end
                if (!ext_rd_n || !ext_wr_n) begin
                    s_cnt++;
                    if (flip && s_cnt == 1) begin
                        cfg_muxed = ~mx; cfg_wait = 3'd5;
                    end
                    check(wr ? (!ext_wr_n && ext_rd_n) : (!ext_rd_n && ext_wr_n), "R6 strobe kind", {ext_rd_n, ext_wr_n}, wr ? 2'b10 : 2'b01);
                    check(ext_addr_hi == a[15:8], "R5 high address in strobe", ext_addr_hi, a[15:8]);
                    if (!mx) check(ext_addr_lo == a[7:0], "R5 low address pins", ext_addr_lo, a[7:0]);
                    if (wr) check(ext_ad_out == d && ext_ad_oe, "R6 write data driven", ext_ad_out, d);
                    else check(!ext_ad_oe, "R6 pins released on read", ext_ad_oe, 0);
                    last_strobe = 1;
                end else if (req_done) begin
                    seen_done = 1;
                    check(last_strobe, "R7 done right after strobe", last_strobe, 1);
                    check(s_cnt == w + 1, flip ? "R9 strobe length captured" : "R6 strobe length", s_cnt, w + 1);
                    check(ale_cnt == int'(mx), mx ? "R4 one ALE cycle" : "R5 no ALE", ale_cnt, mx);
                    if (!wr) check(req_rdata == ext_fn(a), "R7 read data", req_rdata, ext_fn(a));
                end else begin
                    last_strobe = 0;
                end
            end
            @(posedge clk);
            @(negedge clk);
            req_valid = 1'b0;
            #1;
            check(req_done == 1'b0, "R8 done is one cycle", req_done, 0);
            if (wr) begin
                check(ext_wr_cnt - wr_before == w + 1, "R6 write strobe cycles", ext_wr_cnt - wr_before, w + 1);
                check(ext_wr_addr == a && ext_wr_data == d, "R5/R4 write address and data", {ext_wr_addr, ext_wr_data}, {a, d});
            end
        end
        @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog expired actual=timeout expected=completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin : main
        int unsigned seed;
        for (int i = 0; i < 4096; i++) begin
            ram_mem[i] = ram_init(12'(i));
            shadow[i]  = ram_init(12'(i));
        end
        seed = $urandom(32'h0BADC0DE);
        rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_addr = '0; req_wdata = '0;
        cfg_map = 2'b01; cfg_muxed = 1'b0; cfg_wait = '0; bmux = 0;
        repeat (3) @(negedge clk);
        #1;
        check(ext_rd_n && ext_wr_n && !ext_ale && !ext_ad_oe && !req_done, "R10 reset state",
              {ext_rd_n, ext_wr_n, ext_ale, ext_ad_oe, req_done}, 5'b11000);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        run(1, 16'h0FFF, 8'hA5, 2'b01, 0, 3'd0, 0);   // R2 last on-die byte
        run(0, 16'h0FFF, 8'h00, 2'b01, 0, 3'd0, 0);   // R2 read back
        run(0, 16'h1000, 8'h00, 2'b01, 1, 3'd0, 0);   // R2 first off-die byte, R4
        run(1, 16'h0123, 8'h3C, 2'b01, 0, 3'd0, 0);   // R3 write
        run(0, 16'hF123, 8'h00, 2'b00, 0, 3'd0, 0);   // R1 aliasing
        run(0, 16'h0005, 8'h00, 2'b10, 0, 3'd3, 0);   // R1 off-die only, R5
        run(0, 16'h0006, 8'h00, 2'b11, 1, 3'd1, 0);   // R1 mode 11
        run(1, 16'h8421, 8'h96, 2'b10, 1, 3'd2, 0);   // R4 write
        run(1, 16'hBEEF, 8'h5D, 2'b10, 0, 3'd7, 0);   // R6 longest wait
        run(0, 16'h2345, 8'h00, 2'b01, 0, 3'd1, 1);   // R9 config flip
        run(1, 16'h3456, 8'h77, 2'b01, 1, 3'd2, 1);   // R9 config flip

        for (int k = 0; k < 300; k++) begin
            logic [15:0] a;
            int sel;
            sel = $urandom_range(3, 0);
            a = (sel == 0) ? 16'h0FFF : (sel == 1) ? 16'h1000 : 16'($urandom());
            run($urandom_range(1, 0), a, 8'($urandom()), 2'($urandom_range(3, 0)),
                $urandom_range(1, 0), 3'($urandom_range(7, 0)), ($urandom_range(7, 0) == 0));
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule